// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether an instruction takes effect. It reads the 4-bit condition field from the top of a 32-bit instruction word and tests it against four status flags: negative, zero, carry and overflow. The result is a single execute-enable bit. Sixteen codes are defined. There are simple single-flag tests, unsigned and signed compound comparisons, an always-pass code and a never-pass code.

The evaluation itself is purely combinational. By default a register stage follows it, so `exec_o` presents the verdict for the word and flags sampled at the previous rising clock edge. With `PIPE_EN = 0` the stage is removed and the output follows the inputs directly. Reset is asynchronous and active low. Its release is synchronised inside the block by a two-flop stage before it reaches the result register.

Top module: `cond_gate`

## Requirements
- R1: Only bits 31 to 28 of `instr_i` select the condition; bits 27 to 0 have no effect on `exec_o`.
- R2: Code 0000 passes when Z (`flags_i[2]`) is 1; code 0001 passes when Z is 0.
- R3: Code 0010 passes when C (`flags_i[1]`) is 1; code 0011 passes when C is 0.
- R4: Code 0100 passes when N (`flags_i[3]`) is 1, 0101 when N is 0, 0110 when V (`flags_i[0]`) is 1, 0111 when V is 0.
- R5: Code 1000 passes when C is 1 and Z is 0; code 1001 passes when C is 0 or Z is 1.
- R6: Code 1010 passes when N equals V; code 1011 passes when N differs from V.
- R7: Code 1100 passes when Z is 0 and N equals V; code 1101 passes when Z is 1 or N differs from V.
- R8: Code 1110 passes for every flag value.
- R9: Code 1111 never passes; `exec_o` is 0 for every flag value.
- R10: With the default register stage, `exec_o` is 0 while reset is applied, and after a rising edge it shows the verdict for the inputs sampled at that edge. It keeps its previous value until then.
- R11: For every flag value and every code from 0000 to 1101, the code with bit 28 set gives the complement of the code with bit 28 clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word; bits 31:28 hold the condition |
| flags_i | input | 4 | Status flags {N, Z, C, V} |
| exec_o | output | 1 | Execute enable for the sampled instruction |

## Verification
Within one clock the condition field and the flags can change together. The register must then capture both as a pair, and must never pair a new code with the previous flags or the reverse. The bench changes both in the same cycle on every step: an exhaustive sweep over all codes and flag values, each step with fresh random low bits. A behavioural model predicts each verdict one edge later, and the result is compared at the following falling edge. The complement pairs are judged afterwards from the recorded sweep, and a check between the edge and the update confirms that the output holds its old value until the edge.

// File: rtl/cgate_pkg.sv
package cgate_pkg;
  localparam int unsigned COND_W = 4;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flag_t;

  typedef enum logic [COND_W-1:0] {
    C_ZSET   = 4'h0,
    C_ZCLR   = 4'h1,
    C_CSET   = 4'h2,
    C_CCLR   = 4'h3,
    C_NSET   = 4'h4,
    C_NCLR   = 4'h5,
    C_VSET   = 4'h6,
    C_VCLR   = 4'h7,
    C_UGT    = 4'h8,
    C_ULE    = 4'h9,
    C_SGE    = 4'hA,
    C_SLT    = 4'hB,
    C_SGT    = 4'hC,
    C_SLE    = 4'hD,
    C_ALWAYS = 4'hE,
    C_NEVER  = 4'hF
  } cond_e;

  // Codes come in pairs: the upper three bits pick a base test and the
  // lowest bit inverts it.
  localparam int unsigned SEL_W = COND_W - 1;
endpackage

// File: rtl/cgate_rst_sync.sv
module cgate_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cgate_base_sel.sv
module cgate_base_sel
  import cgate_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  flag_t            flags_i,
  output logic             base_o
);
  logic sign_ok;

  always_comb begin
    sign_ok = (flags_i.n == flags_i.v);
    unique case (sel_i)
      3'd0:    base_o = flags_i.z;
      3'd1:    base_o = flags_i.c;
      3'd2:    base_o = flags_i.n;
      3'd3:    base_o = flags_i.v;
      3'd4:    base_o = flags_i.c & ~flags_i.z;
      3'd5:    base_o = sign_ok;
      3'd6:    base_o = ~flags_i.z & sign_ok;
      default: base_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cgate_polarity.sv
module cgate_polarity (
  input  logic base_i,
  input  logic invert_i,
  output logic pass_o
);
  always_comb begin
    pass_o = invert_i ? ~base_i : base_i;
  end
endmodule

// File: rtl/cond_gate.sv
module cond_gate
  import cgate_pkg::*;
#(
  parameter int unsigned INSTR_W  = 32,
  parameter int unsigned COND_MSB = 31,
  parameter bit          PIPE_EN  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [3:0]         flags_i,
  output logic               exec_o
);
  localparam int unsigned COND_LSB = COND_MSB - COND_W + 1;

  logic [COND_W-1:0] cond_field;
  flag_t             flags;
  logic              base;
  logic              pass;
  logic              rst_sync_n;

  assign cond_field = instr_i[COND_MSB:COND_LSB];
  assign flags      = flag_t'(flags_i);

  cgate_base_sel u_base (
    .sel_i   (cond_field[COND_W-1:1]),
    .flags_i (flags),
    .base_o  (base)
  );

  cgate_polarity u_pol (
    .base_i   (base),
    .invert_i (cond_field[0]),
    .pass_o   (pass)
  );

  cgate_rst_sync #(.STAGES(2)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  generate
    if (PIPE_EN) begin : g_reg
      logic exec_q;
      logic exec_d;
      always_comb begin
        exec_d = pass;
      end
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) exec_q <= 1'b0;
        else             exec_q <= exec_d;
      end
      assign exec_o = exec_q;
    end else begin : g_comb
      assign exec_o = pass;
    end
  endgenerate
endmodule

// File: rtl/cond_gate_chk.sv
module cond_gate_chk #(
  parameter int unsigned INSTR_W  = 32,
  parameter int unsigned COND_MSB = 31,
  parameter bit          PIPE_EN  = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_sync_n,
  input logic [INSTR_W-1:0] instr_i,
  input logic [3:0]         flags_i,
  input logic               exec_o
);
  logic [3:0] code;
  assign code = instr_i[COND_MSB -: 4];

  generate
    if (PIPE_EN) begin : g_chk
      always @(posedge clk) begin
        if (!rst_n) begin
          assert_reset_low_R10: assert (exec_o == 1'b0);
        end
      end

      assert_always_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
        code == 4'hE |=> exec_o);

      assert_never_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
        code == 4'hF |=> !exec_o);

      assert_zero_set_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
        code == 4'h0 |=> exec_o == $past(flags_i[2]));

      assert_carry_clr_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
        code == 4'h3 |=> exec_o == !$past(flags_i[1]));

      assert_sign_ge_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        code == 4'hA |=> exec_o == ($past(flags_i[3]) == $past(flags_i[0])));

      assert_ugt_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        code == 4'h8 |=> exec_o == ($past(flags_i[1]) && !$past(flags_i[2])));
    end
  endgenerate
endmodule

bind cond_gate cond_gate_chk #(
  .INSTR_W  (INSTR_W),
  .COND_MSB (COND_MSB),
  .PIPE_EN  (PIPE_EN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .instr_i    (instr_i),
  .flags_i    (flags_i),
  .exec_o     (exec_o)
);

// File: tb/cond_gate_bench.sv
`timescale 1ns/1ps
module cond_gate_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr_i;
  logic [3:0]  flags_i;
  logic        exec_o;

  int tests_run;
  int tests_failed;
  bit done;
  bit sweep [16][16];

  cond_gate u_cond_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .instr_i (instr_i),
    .flags_i (flags_i),
    .exec_o  (exec_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit model(input int code, input logic [3:0] f);
    bit n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (code)
      0:  return z;                 // R2
      1:  return !z;                // R2
      2:  return c;                 // R3
      3:  return !c;                // R3
      4:  return n;                 // R4
      5:  return !n;                // R4
      6:  return v;                 // R4
      7:  return !v;                // R4
      8:  return c && !z;           // R5
      9:  return !c || z;           // R5
      10: return n == v;            // R6
      11: return n != v;            // R6
      12: return !z && (n == v);    // R7
      13: return z || (n != v);     // R7
      14: return 1'b1;              // R8
      default: return 1'b0;         // R9
    endcase
  endfunction

  function automatic string req_of(input int code);
    case (code)
      0, 1:          return "R2";
      2, 3:          return "R3";
      4, 5, 6, 7:    return "R4";
      8, 9:          return "R5";
      10, 11:        return "R6";
      12, 13:        return "R7";
      14:            return "R8";
      default:       return "R9";
    endcase
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: exec_o=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic step(input int code, input logic [3:0] f,
                      input logic [27:0] low, input string req, output bit got);
    bit exp;
    @(negedge clk);
    instr_i = {code[3:0], low};
    flags_i = f;
    exp = model(code, f);
    @(negedge clk);
    got = exec_o;
    check(req, got, exp);
  endtask

  initial begin
    bit r;
    tests_run = 0; tests_failed = 0; done = 1'b0;
    rst_n = 1'b0;
    instr_i = {4'hE, 28'h0};
    flags_i = 4'h0;
    repeat (3) @(negedge clk);
    check("R10", exec_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Exhaustive sweep: code and flags change together every step.
    for (int code = 0; code < 16; code++) begin
      for (int f = 0; f < 16; f++) begin
        step(code, f[3:0], 28'($urandom), req_of(code), r);
        sweep[code][f] = r;
      end
    end

    // R11: complement pairs across the recorded sweep.
    for (int p = 0; p < 14; p += 2) begin
      for (int f = 0; f < 16; f++) begin
        check("R11", sweep[p+1][f], !sweep[p][f]);
      end
    end

    // R1: low bits mimic other codes but must not matter.
    step(14, 4'h0, 28'hF00_0000, "R1", r);
    step(15, 4'hF, 28'hEFF_FFFF, "R1", r);
    step(0, 4'h4, 28'h1FF_FFFF, "R1", r);
    step(1, 4'h4, 28'h000_0000, "R1", r);

    // R10: output holds until the next rising edge.
    step(15, 4'h0, 28'h0, "R10", r);
    @(negedge clk);
    instr_i = {4'hE, 28'h0};
    #2;
    check("R10", exec_o, 1'b0);
    @(negedge clk);
    check("R10", exec_o, 1'b1);

    // R10: asynchronous reset clears the result mid-run.
    #3 rst_n = 1'b0;
    #1 check("R10", exec_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", exec_o, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL R10: watchdog expired exec_o=%0b expected=completion", exec_o);
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule